// File: doc/BRIEF.md
# Split-Section Binary Divider Counter

A four-bit counter made of two sections that can run apart or together. The low section is a single toggle stage that divides by two. The high section has three stages that count up in natural binary and divide by eight. Each section has its own count-pulse input. A section advances on a high-to-low transition of that input. Both pulse inputs and the clear request are brought into one system clock domain through two-flop synchronizers. Transitions are then found by comparing successive samples, so the design never uses a pulse input as a clock.

A static mode pin joins the two sections. When it is set, a one-to-zero step of the low stage is the count event for the high section. The four outputs then form one binary count that divides by 2, 4, 8 and 16. When it is clear, the high section counts its own input pulses, and its three outputs divide those pulses by 2, 4 and 8. The low stage then serves as a separate divide-by-two that shares the clear. The clear needs two request pins high together. It zeroes all stages and wins over any count.

There is no data stream here, so every pin is a plain level with no handshake.

Top module: `split_divider`

## Requirements
- R1: While `rst_n` is low, and after it is released with all inputs idle, `cnt_out` is 4'b0000.
- R2: A high-to-low transition on `cnt_a_in` inverts `cnt_out[0]`, with no clear active.
- R3: A low-to-high transition on `cnt_a_in` or `cnt_b_in` leaves `cnt_out` unchanged.
- R4: With `chain_en` = 0, each high-to-low transition on `cnt_b_in` adds one to `cnt_out[3:1]`. Bit 1 is the least significant bit.
- R5: With `chain_en` = 1, each high-to-low transition on `cnt_a_in` adds one to the whole of `cnt_out`, read as a 4-bit binary number. After 15 the count wraps to 0.
- R6: With `chain_en` = 1, `cnt_b_in` has no effect. This holds even when it falls in the same cycle that the low stage steps from 1 to 0, so that carry counts once.
- R7: Only one of `clr_a` and `clr_b` high does not change `cnt_out`.
- R8: While `clr_a` and `clr_b` are both high, `cnt_out` goes to zero and stays there, whatever happens on the pulse inputs.
- R9: With `chain_en` = 0, the high section wrapping from 7 to 0 and any `cnt_b_in` activity leave `cnt_out[0]` unchanged.
- R10: An input change made between clock edges shows on `cnt_out` just after the third following rising edge of `clk`. The three registers on the path are two synchronizer flops and the state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a_in | input | 1 | Count pulses for the divide-by-two stage; counts on falling edge |
| cnt_b_in | input | 1 | Count pulses for the three-stage section when not chained |
| chain_en | input | 1 | 1: low stage carries into high section; 0: sections separate |
| clr_a | input | 1 | Clear request, first half of the AND pair |
| clr_b | input | 1 | Clear request, second half of the AND pair |
| cnt_out | output | 4 | Stage outputs; bit 0 is the divide-by-two stage |

## Verification
A bad toggle or carry inside the design is not hidden anywhere. The state register drives `cnt_out` directly, so a wrong internal state is visible on the ports in the same cycle that it is stored. A lost or doubled carry shows as a wrong high-section value at the first low-stage 1-to-0 step. A stuck synchronizer stage shows as a count that arrives one cycle early or late. Because the bench compares the count with its reference on every cycle, the timing of each step is checked as closely as its value.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  parameter int SYNC_DEPTH = 2;
  parameter int HI_STAGES  = 3;
  localparam int TOTAL_W   = 1 + HI_STAGES;
endpackage

// File: rtl/sdiv_sync.sv
module sdiv_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[0] <= '0;
        else        st[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[i] <= '0;
        else        st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sdiv_fall_det.sv
module sdiv_fall_det #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= cur;

  assign fall = prev & ~cur;
endmodule

// File: rtl/sdiv_toggle.sv
module sdiv_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic evt,
  output logic q,
  output logic carry
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (evt) q <= ~q;

  // stage steps 1 -> 0 this cycle: the next stage's count event
  assign carry = evt & q & ~clr;
endmodule

// File: rtl/sdiv_bin_sec.sv
module sdiv_bin_sec #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         evt,
  output logic [N-1:0] q
);
  logic [N:0] chain;
  assign chain[0] = evt;

  for (genvar i = 0; i < N; i++) begin : g_bit
    sdiv_toggle u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .evt   (chain[i]),
      .q     (q[i]),
      .carry (chain[i+1])
    );
  end
endmodule

// File: rtl/split_divider.sv
module split_divider
  import sdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_a_in,
  input  logic               cnt_b_in,
  input  logic               chain_en,
  input  logic               clr_a,
  input  logic               clr_b,
  output logic [TOTAL_W-1:0] cnt_out
);
  logic [2:0] raw_in, sync_in;
  logic [1:0] falls;
  logic       clr_q, a_fall, b_fall, a_carry, b_evt, q_lo;
  logic [HI_STAGES-1:0] q_hi;

  assign raw_in = {clr_a & clr_b, cnt_b_in, cnt_a_in};

  sdiv_sync #(.W(3), .STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk), .rst_n (rst_n), .d (raw_in), .q (sync_in)
  );

  sdiv_fall_det #(.W(2)) u_fall (
    .clk (clk), .rst_n (rst_n), .cur (sync_in[1:0]), .fall (falls)
  );

  assign clr_q  = sync_in[2];
  assign a_fall = falls[0];
  assign b_fall = falls[1];

  sdiv_toggle u_lo (
    .clk (clk), .rst_n (rst_n), .clr (clr_q), .evt (a_fall),
    .q (q_lo), .carry (a_carry)
  );

  // chained: only the low stage's carry counts; external pulses ignored
  assign b_evt = chain_en ? a_carry : b_fall;

  sdiv_bin_sec #(.N(HI_STAGES)) u_hi (
    .clk (clk), .rst_n (rst_n), .clr (clr_q), .evt (b_evt), .q (q_hi)
  );

  assign cnt_out = {q_hi, q_lo};
endmodule

// File: rtl/sdiv_checker.sv
module sdiv_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         chain_en,
  input logic         clr_q,
  input logic         a_fall,
  input logic         b_evt,
  input logic [W-1:0] q
);
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> (q == '0));

  p_lo_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_q && !a_fall) |=> $stable(q[0]));

  p_lo_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_q && a_fall) |=> (q[0] != $past(q[0])));

  p_hi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_q && !b_evt) |=> $stable(q[W-1:1]));

  p_hi_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_q && b_evt) |=> (q[W-1:1] == $past(q[W-1:1]) + 1'b1));

  p_chain_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_en && !clr_q && !(a_fall && q[0])) |=> $stable(q[W-1:1]));
endmodule

bind split_divider sdiv_checker #(.W(sdiv_pkg::TOTAL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chain_en (chain_en),
  .clr_q    (clr_q),
  .a_fall   (a_fall),
  .b_evt    (b_evt),
  .q        (cnt_out)
);

// File: tb/sim_split_divider.sv
`timescale 1ns/1ps
module sim_split_divider;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_a_in = 1'b0, cnt_b_in = 1'b0, chain_en = 1'b0;
  logic clr_a = 1'b0, clr_b = 1'b0;
  logic [3:0] cnt_out;
  int n_chk = 0, n_fail = 0;
  logic running = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  split_divider u0 (
    .clk (clk), .rst_n (rst_n), .cnt_a_in (cnt_a_in), .cnt_b_in (cnt_b_in),
    .chain_en (chain_en), .clr_a (clr_a), .clr_b (clr_b), .cnt_out (cnt_out)
  );

  // behavioural reference: input delay line of three samples, integer counts
  logic a1, a2, a3, b1, b2, b3, c1, c2;
  int   lo, hi;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {a1, a2, a3, b1, b2, b3, c1, c2} <= '0;
      lo <= 0; hi <= 0;
    end else begin
      a1 <= cnt_a_in; a2 <= a1; a3 <= a2;
      b1 <= cnt_b_in; b2 <= b1; b3 <= b2;
      c1 <= clr_a && clr_b; c2 <= c1;
      if (c2) begin
        lo <= 0; hi <= 0;
      end else begin
        if (a3 && !a2) begin
          lo <= 1 - lo;
          if (chain_en && lo == 1) hi <= (hi + 1) % 8;
        end
        if (!chain_en && b3 && !b2) hi <= (hi + 1) % 8;
      end
    end

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // R10: every cycle, output against reference with three-edge latency
  always @(negedge clk)
    if (running && rst_n) chk("R10", cnt_out, 4'(hi * 2 + lo));

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_a();
    cnt_a_in = 1'b1; idle(4);
    cnt_a_in = 1'b0; idle(4);
  endtask

  task automatic pulse_b();
    cnt_b_in = 1'b1; idle(4);
    cnt_b_in = 1'b0; idle(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    chk("R1", cnt_out, 4'b0000);
    rst_n = 1'b1;
    idle(3);
    chk("R1", cnt_out, 4'b0000);
    running = 1'b1;

    pulse_a();  chk("R2", cnt_out, 4'b0001);
    pulse_a();  chk("R2", cnt_out, 4'b0000);

    cnt_a_in = 1'b1; idle(6);
    chk("R3", cnt_out, 4'b0000);
    cnt_a_in = 1'b0; idle(4);
    chk("R2", cnt_out, 4'b0001);
    cnt_b_in = 1'b1; idle(6);
    chk("R3", cnt_out, 4'b0001);
    cnt_b_in = 1'b0; idle(4);
    chk("R4", cnt_out, 4'b0011);

    pulse_b(); pulse_b();
    chk("R4", cnt_out, 4'b0111);
    for (int i = 0; i < 5; i++) pulse_b();
    chk("R9", cnt_out, 4'b0001);

    clr_a = 1'b1; idle(6);
    chk("R7", cnt_out, 4'b0001);
    clr_a = 1'b0; clr_b = 1'b1; idle(6);
    chk("R7", cnt_out, 4'b0001);
    clr_a = 1'b1; idle(4);
    chk("R8", cnt_out, 4'b0000);
    pulse_a(); pulse_b();
    chk("R8", cnt_out, 4'b0000);
    clr_a = 1'b0; clr_b = 1'b0; idle(4);

    chain_en = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      pulse_a();
      chk("R5", cnt_out, 4'(i % 16));
    end
    pulse_b();
    chk("R6", cnt_out, 4'b0000);
    pulse_a();
    chk("R5", cnt_out, 4'b0001);
    cnt_a_in = 1'b1; cnt_b_in = 1'b1; idle(4);
    cnt_a_in = 1'b0; cnt_b_in = 1'b0; idle(4);
    chk("R6", cnt_out, 4'b0010);

    running = 1'b0;
    finish_run();
  end
endmodule